// File: doc/BRIEF.md
# I2C Slave Transmitter with Host Refill Handshake

This block is the slave side of an I2C bus that answers read requests. After a start condition it collects the first frame, compares its upper seven bits with a programmed slave address and, on a match, drives the acknowledge bit to a host-chosen level on the ninth clock. When the direction bit of that frame is 1, the block sets its transmit-mode flag and its transmit-empty flag at once and moves into transmit mode without any host action.

The host feeds bytes through a one-deep holding register in front of the shift register. Each time the empty flag rises, the host writes the next byte. If the shifter needs a byte and the holding register is empty, the block stretches the clock by pulling SCL low until a byte arrives. When a byte and its acknowledge clock finish while the holding register is empty, the transmit-end flag rises and SCL stays low. The host ends the transfer by clearing the transmit-mode flag, then issuing a dummy receive-data read that lets SCL go, and finally clearing the empty flag. Both bus lines are open-drain: each has a sensed input, a drive-enable output and a constant low data output.

Top module: `i2cs_slave_tx`

## Requirements
- R1: While `mod_en` is 0 no bus activity is recognised: `scl_drive` and `sda_drive` are 0 one cycle later and stay 0, and no flag is set. After reset all flags and both drive enables are 0.
- R2: The first frame after a start is received MSB first on SCL rising edges; if bits 7..1 equal `slv_addr`, the slave sets `sda_drive` = NOT `ack_val` for the whole ninth clock (`ack_val`=0 means acknowledge by pulling SDA low). On a mismatch SDA is never driven until the next start.
- R3: A matched frame with bit 0 (direction) = 1 sets `xmit` and `xempty` at the ninth SCL rising edge; a matched frame with bit 0 = 0 leaves `xmit` at 0 and the slave ignores the rest of the transfer.
- R4: In transmit mode the shifter presents bits 7 down to 0 on clocks 1 to 8 (`sda_drive` = NOT bit) and releases SDA for clock 9; `sda_drive` changes only while SCL is low.
- R5: A `txd_wr` pulse stores `txd` and clears `xempty`; when the shifter takes the stored byte `xempty` returns to 1, so a byte written during one transfer is sent in the next byte slot.
- R6: If the shifter needs a byte while `xempty` is 1, `scl_drive` holds SCL low until a byte is written; the first bit is then presented and SCL is released.
- R7: If `xempty` is 1 when the ninth clock of a data byte falls, `xend` is set and SCL is held low; `xend_clr` clears `xend`.
- R8: SCL held after `xend` is released only by an `rxd_rd` pulse while `xmit` is 0; `rxd_rd` while `xmit` is 1 leaves SCL held. `xmit_clr` clears `xmit`.
- R9: If the master does not acknowledge (SDA high on the ninth rising edge) while a byte is waiting, that byte is not loaded: `xempty` stays 0 and both lines are released until the next start or stop.
- R10: A stop (SDA rising while SCL high) at any point returns the block to idle with both lines released; a later start with a matching address is acknowledged normally.
- R11: `rxd` takes the full 8-bit address frame on a match and is unchanged by a mismatching frame.
- R12: `xempty_clr` clears `xempty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples both bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable |
| slv_addr | input | 7 | Own 7-bit slave address |
| ack_val | input | 1 | Level driven in the address acknowledge slot |
| txd_wr | input | 1 | Strobe: store `txd` in the holding register |
| txd | input | 8 | Transmit byte |
| xmit_clr | input | 1 | Strobe: clear transmit-mode flag |
| xend_clr | input | 1 | Strobe: clear transmit-end flag (write-one-to-clear) |
| xempty_clr | input | 1 | Strobe: clear transmit-empty flag |
| rxd_rd | input | 1 | Strobe: receive-data read, releases a held SCL |
| scl_in | input | 1 | Sensed SCL level |
| scl_drive | output | 1 | 1 pulls SCL low |
| scl_out | output | 1 | Data level for SCL driver, always 0 |
| sda_in | input | 1 | Sensed SDA level |
| sda_drive | output | 1 | 1 pulls SDA low |
| sda_out | output | 1 | Data level for SDA driver, always 0 |
| xmit | output | 1 | Transmit-mode flag |
| xempty | output | 1 | Transmit-empty flag |
| xend | output | 1 | Transmit-end flag |
| rxd | output | 8 | Last matched address frame |

## Verification
The hardest case to reach from the ports is a clock stretch in the middle of a master clock: the master has already released SCL for the first data bit while the holding register is still empty, so the line must stay low until the host reacts. The bench gets there by running the master's first data clock and a delayed host write in parallel. The master waits on the sensed SCL level while the host branch checks that the line is still low after several dozen cycles and only then supplies the byte. A second hard spot is the end-of-transfer release, which is reached by leaving the holding register empty through the last acknowledge. The bench then tries the dummy read once with the transmit-mode flag still set and once after clearing it.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AMATCH,
    ST_AACK,
    ST_HOLD,
    ST_TXBIT,
    ST_TXACK,
    ST_DONE,
    ST_WAIT
  } i2cs_state_e;

endpackage

// File: rtl/i2cs_rst_sync.sv
module i2cs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/i2cs_line_mon.sv
module i2cs_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  assign scl_rise  = scl_in & ~scl_q;
  assign scl_fall  = ~scl_in & scl_q;
  // SDA edges only count as conditions while SCL stays high across both samples
  assign start_det = scl_in & scl_q & sda_q & ~sda_in;
  assign stop_det  = scl_in & scl_q & ~sda_q & sda_in;

endmodule

// File: rtl/i2cs_tx_buf.sv
module i2cs_tx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txd_wr,
  input  logic [DATA_W-1:0] txd,
  input  logic              set_tx,
  input  logic              load_pulse,
  input  logic              set_tend,
  input  logic              xmit_clr,
  input  logic              xend_clr,
  input  logic              xempty_clr,
  output logic [DATA_W-1:0] tdr,
  output logic              xmit,
  output logic              xempty,
  output logic              xend
);

  logic [DATA_W-1:0] tdr_d;
  logic              xmit_d;
  logic              xempty_d;
  logic              xend_d;

  always_comb begin
    tdr_d    = tdr;
    xmit_d   = xmit;
    xempty_d = xempty;
    xend_d   = xend;

    if (xmit_clr) xmit_d = 1'b0;
    if (set_tx)   xmit_d = 1'b1;

    if (xend_clr) xend_d = 1'b0;
    if (set_tend) xend_d = 1'b1;

    // lowest to highest priority: host clear, shifter take-up, host write
    if (xempty_clr)            xempty_d = 1'b0;
    if (set_tx || load_pulse)  xempty_d = 1'b1;
    if (txd_wr) begin
      xempty_d = 1'b0;
      tdr_d    = txd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr    <= '0;
      xmit   <= 1'b0;
      xempty <= 1'b0;
      xend   <= 1'b0;
    end else begin
      if (txd_wr) tdr <= tdr_d;
      xmit   <= xmit_d;
      xempty <= xempty_d;
      xend   <= xend_d;
    end
  end

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic [DATA_W-2:0] slv_addr,
  input  logic              ack_val,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_in,
  input  logic              xempty,
  input  logic              xmit,
  input  logic [DATA_W-1:0] tdr,
  input  logic              rxd_rd,
  output logic              set_tx,
  output logic              load_pulse,
  output logic              set_tend,
  output logic              scl_drive,
  output logic              sda_drive,
  output logic [DATA_W-1:0] rxd
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_ADDR_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL_BYTE     = CNT_W'(DATA_W);

  i2cs_state_e       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] rxd_q, rxd_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              sdad_q, sdad_d;
  logic              scld_q, scld_d;
  logic [DATA_W-1:0] frame;
  logic              sh_en;

  assign frame = {sh_q[DATA_W-2:0], sda_in};

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    rxd_d      = rxd_q;
    rw_d       = rw_q;
    mack_d     = mack_q;
    sdad_d     = sdad_q;
    scld_d     = scld_q;
    set_tx     = 1'b0;
    load_pulse = 1'b0;
    set_tend   = 1'b0;

    if (!mod_en || stop_det) begin
      st_d   = ST_IDLE;
      sdad_d = 1'b0;
      scld_d = 1'b0;
    end else if (start_det) begin
      st_d   = ST_ADDR;
      cnt_d  = '0;
      sdad_d = 1'b0;
      scld_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = frame;
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q == LAST_ADDR_BIT) begin
              if (frame[DATA_W-1:1] == slv_addr) begin
                rw_d  = frame[0];
                rxd_d = frame;
                st_d  = ST_AMATCH;
              end else begin
                st_d = ST_WAIT;
              end
            end
          end
        end
        ST_AMATCH: begin
          if (scl_fall) begin
            sdad_d = ~ack_val;
            st_d   = ST_AACK;
          end
        end
        ST_AACK: begin
          if (scl_rise && rw_q) set_tx = 1'b1;
          if (scl_fall) begin
            sdad_d = 1'b0;
            st_d   = (rw_q && !ack_val) ? ST_HOLD : ST_WAIT;
          end
        end
        ST_HOLD: begin
          if (!xempty) begin
            load_pulse = 1'b1;
            sh_d       = tdr;
            sdad_d     = ~tdr[DATA_W-1];
            scld_d     = 1'b0;
            cnt_d      = '0;
            st_d       = ST_TXBIT;
          end else begin
            scld_d = 1'b1;
          end
        end
        ST_TXBIT: begin
          if (scl_rise) cnt_d = cnt_q + CNT_W'(1);
          if (scl_fall) begin
            if (cnt_q == FULL_BYTE) begin
              sdad_d = 1'b0;
              st_d   = ST_TXACK;
            end else begin
              sh_d   = {sh_q[DATA_W-2:0], 1'b0};
              sdad_d = ~sh_q[DATA_W-2];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) mack_d = ~sda_in;
          if (scl_fall) begin
            if (xempty) begin
              set_tend = 1'b1;
              scld_d   = 1'b1;
              st_d     = ST_DONE;
            end else if (!mack_q) begin
              st_d = ST_WAIT;
            end else begin
              st_d = ST_HOLD;
            end
          end
        end
        ST_DONE: begin
          scld_d = 1'b1;
          if (rxd_rd && !xmit) begin
            scld_d = 1'b0;
            st_d   = ST_WAIT;
          end
        end
        default: begin
          sdad_d = 1'b0;
          scld_d = 1'b0;
        end
      endcase
    end
  end

  assign sh_en = (sh_d != sh_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      rxd_q  <= '0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      sdad_q <= 1'b0;
      scld_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      if (sh_en) sh_q <= sh_d;
      rxd_q  <= rxd_d;
      rw_q   <= rw_d;
      mack_q <= mack_d;
      sdad_q <= sdad_d;
      scld_q <= scld_d;
    end
  end

  assign scl_drive = scld_q;
  assign sda_drive = sdad_q;
  assign rxd       = rxd_q;

endmodule

// File: rtl/i2cs_slave_tx.sv
module i2cs_slave_tx #(
  parameter int DATA_W     = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic [DATA_W-2:0] slv_addr,
  input  logic              ack_val,
  input  logic              txd_wr,
  input  logic [DATA_W-1:0] txd,
  input  logic              xmit_clr,
  input  logic              xend_clr,
  input  logic              xempty_clr,
  input  logic              rxd_rd,
  input  logic              scl_in,
  output logic              scl_drive,
  output logic              scl_out,
  input  logic              sda_in,
  output logic              sda_drive,
  output logic              sda_out,
  output logic              xmit,
  output logic              xempty,
  output logic              xend,
  output logic [DATA_W-1:0] rxd
);

  logic              rst_core_n;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              set_tx;
  logic              load_pulse;
  logic              set_tend;
  logic [DATA_W-1:0] tdr;

  i2cs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  i2cs_line_mon u_mon (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_tx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .txd_wr     (txd_wr),
    .txd        (txd),
    .set_tx     (set_tx),
    .load_pulse (load_pulse),
    .set_tend   (set_tend),
    .xmit_clr   (xmit_clr),
    .xend_clr   (xend_clr),
    .xempty_clr (xempty_clr),
    .tdr        (tdr),
    .xmit       (xmit),
    .xempty     (xempty),
    .xend       (xend)
  );

  i2cs_engine #(.DATA_W(DATA_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .mod_en     (mod_en),
    .slv_addr   (slv_addr),
    .ack_val    (ack_val),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_in     (sda_in),
    .xempty     (xempty),
    .xmit       (xmit),
    .tdr        (tdr),
    .rxd_rd     (rxd_rd),
    .set_tx     (set_tx),
    .load_pulse (load_pulse),
    .set_tend   (set_tend),
    .scl_drive  (scl_drive),
    .sda_drive  (sda_drive),
    .rxd        (rxd)
  );

  assign scl_out = 1'b0;
  assign sda_out = 1'b0;

endmodule

// File: rtl/i2cs_slave_tx_chk.sv
module i2cs_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic mod_en,
  input logic scl_in,
  input logic scl_drive,
  input logic sda_drive,
  input logic txd_wr,
  input logic xmit,
  input logic xempty,
  input logic xend
);

  // R1: a disabled block releases both lines on the next cycle
  assert_disabled_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (!scl_drive && !sda_drive));

  // R4: the SDA drive only moves while SCL is sensed low
  assert_sda_moves_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mod_en) && (sda_drive != $past(sda_drive))) |-> !$past(scl_in));

  // R3: entering transmit mode raises the empty flag in the same step
  assert_tx_entry_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xmit) |-> (xempty || $past(txd_wr)));

  // R7: transmit-end only rises when the holding register was empty
  assert_end_needs_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xend) |-> $past(xempty));

endmodule

bind i2cs_slave_tx i2cs_slave_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .mod_en    (mod_en),
  .scl_in    (scl_in),
  .scl_drive (scl_drive),
  .sda_drive (sda_drive),
  .txd_wr    (txd_wr),
  .xmit      (xmit),
  .xempty    (xempty),
  .xend      (xend)
);

// File: tb/tb_i2cs_slave_tx.sv
`timescale 1ns/1ps
module tb_i2cs_slave_tx;

  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h5A;

  logic       clk;
  logic       rst_n;
  logic       mod_en;
  logic [6:0] slv_addr;
  logic       ack_val;
  logic       txd_wr;
  logic [7:0] txd;
  logic       xmit_clr, xend_clr, xempty_clr, rxd_rd;
  logic       m_scl, m_sda;
  wire        scl_in, sda_in;
  logic       scl_drive, scl_out, sda_drive, sda_out;
  logic       xmit, xempty, xend;
  logic [7:0] rxd;

  int n_checks = 0;
  int n_fail   = 0;

  assign scl_in = m_scl & ~scl_drive;
  assign sda_in = m_sda & ~sda_drive;

  i2cs_slave_tx dut (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .slv_addr(slv_addr),
    .ack_val(ack_val), .txd_wr(txd_wr), .txd(txd), .xmit_clr(xmit_clr),
    .xend_clr(xend_clr), .xempty_clr(xempty_clr), .rxd_rd(rxd_rd),
    .scl_in(scl_in), .scl_drive(scl_drive), .scl_out(scl_out),
    .sda_in(sda_in), .sda_drive(sda_drive), .sda_out(sda_out),
    .xmit(xmit), .xempty(xempty), .xend(xend), .rxd(rxd)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    txd = d; txd_wr = 1'b1; wclk(1); txd_wr = 1'b0;
  endtask
  task automatic pulse_xmit_clr();   xmit_clr = 1'b1;   wclk(1); xmit_clr = 1'b0;   endtask
  task automatic pulse_xend_clr();   xend_clr = 1'b1;   wclk(1); xend_clr = 1'b0;   endtask
  task automatic pulse_xempty_clr(); xempty_clr = 1'b1; wclk(1); xempty_clr = 1'b0; endtask
  task automatic pulse_rd();         rxd_rd = 1'b1;     wclk(1); rxd_rd = 1'b0;     endtask

  task automatic bus_start();
    m_sda = 1'b1; wclk(Q);
    m_scl = 1'b1; wclk(Q);
    m_sda = 1'b0; wclk(Q);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; wclk(Q);
    m_sda = 1'b0; wclk(Q);
    m_scl = 1'b1; wclk(Q);
    m_sda = 1'b1; wclk(Q);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    int guard;
    m_sda = b; wclk(Q);
    m_scl = 1'b1;
    guard = 0;
    while (scl_in == 1'b0 && guard < 3000) begin
      wclk(1);
      guard++;
    end
    wclk(Q/2);
    seen = sda_in;
    wclk(Q/2);
    m_scl = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
    clock_bit(1'b1, ack);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clock_bit(mack, s);
  endtask

  // host end processing while the slave holds SCL after the last byte
  task automatic end_proc(input string tag);
    m_scl = 1'b1; wclk(10);
    chk({tag, " R8 scl held after end"}, scl_in, 1'b0);
    pulse_rd(); wclk(5);
    chk({tag, " R8 read with xmit set keeps hold"}, scl_in, 1'b0);
    pulse_xmit_clr();
    chk({tag, " R8 xmit cleared"}, xmit, 1'b0);
    pulse_rd(); wclk(5);
    chk({tag, " R8 dummy read releases scl"}, scl_in, 1'b1);
    pulse_xend_clr(); wclk(1);
    chk({tag, " R7 xend cleared"}, xend, 1'b0);
    pulse_xempty_clr(); wclk(1);
    chk({tag, " R12 xempty cleared"}, xempty, 1'b0);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 reset xmit", xmit, 1'b0);
    chk("R1 reset xempty", xempty, 1'b0);
    chk("R1 reset xend", xend, 1'b0);
    chk("R1 reset drives", {scl_drive, sda_drive}, 2'b00);
  endtask

  task automatic t_read_basic();
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    chk("R2 address acknowledged", ack, 1'b0);
    chk("R3 xmit set on read", xmit, 1'b1);
    chk("R3 xempty set on read", xempty, 1'b1);
    chk("R11 rxd holds address frame", rxd, {ADDR, 1'b1});
    chk("R6 scl stretched with empty buffer", scl_drive, 1'b1);
    pulse_wr(8'hA5); wclk(3);
    chk("R5 byte taken, xempty set again", xempty, 1'b1);
    chk("R6 scl released after write", scl_drive, 1'b0);
    pulse_wr(8'h3C); wclk(1);
    chk("R5 write clears xempty", xempty, 1'b0);
    read_byte(1'b0, d);
    chk("R4 first byte msb first", d, 8'hA5);
    chk("R5 queued byte loaded", xempty, 1'b1);
    chk("R7 no end while byte pending", xend, 1'b0);
    read_byte(1'b1, d);
    chk("R4 second byte", d, 8'h3C);
    chk("R7 xend after last byte", xend, 1'b1);
    chk("R7 scl held after last byte", scl_drive, 1'b1);
    end_proc("read_basic");
  endtask

  task automatic t_stretch();
    logic ack, b0, s;
    logic [7:0] d;
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    chk("R6 stretch address ack", ack, 1'b0);
    fork
      clock_bit(1'b1, b0);
      begin
        wclk(Q + 40);
        chk("R6 scl low while master waits", scl_in, 1'b0);
        pulse_wr(8'h4E);
      end
    join
    d = {7'd0, b0};
    for (int i = 0; i < 7; i++) begin
      clock_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clock_bit(1'b1, s);
    chk("R6 byte after stretch", d, 8'h4E);
    chk("R7 xend after stretched byte", xend, 1'b1);
    end_proc("stretch");
  endtask

  task automatic t_nack();
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    pulse_wr(8'h11); wclk(3);
    pulse_wr(8'h22); wclk(1);
    read_byte(1'b1, d);
    chk("R9 byte before nack", d, 8'h11);
    chk("R9 pending byte not loaded", xempty, 1'b0);
    chk("R9 lines released", {scl_drive, sda_drive}, 2'b00);
    chk("R9 no end flag", xend, 1'b0);
    read_byte(1'b1, d);
    chk("R9 slave silent after nack", d, 8'hFF);
    // repeated start then stop
    bus_start();
    bus_stop();
    chk("R10 idle after stop", {scl_drive, sda_drive}, 2'b00);
    pulse_xmit_clr();
    pulse_xempty_clr();
  endtask

  task automatic t_mismatch();
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({7'h5B, 1'b1}, ack);
    chk("R2 mismatch not acknowledged", ack, 1'b1);
    chk("R3 mismatch leaves xmit", xmit, 1'b0);
    chk("R11 rxd unchanged on mismatch", rxd, {ADDR, 1'b1});
    read_byte(1'b1, d);
    chk("R2 sda never driven on mismatch", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_write_addr();
    logic ack;
    bus_start();
    send_byte({ADDR, 1'b0}, ack);
    chk("R2 write address acknowledged", ack, 1'b0);
    chk("R3 write address leaves xmit", xmit, 1'b0);
    chk("R11 rxd write frame", rxd, {ADDR, 1'b0});
    send_byte(8'h55, ack);
    chk("R3 write data ignored", ack, 1'b1);
    bus_stop();
  endtask

  task automatic t_ack_level();
    logic ack;
    ack_val = 1'b1;
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    chk("R2 ack level 1 leaves sda released", ack, 1'b1);
    chk("R3 flags still set with ack level 1", {xmit, xempty}, 2'b11);
    chk("R6 no stretch after own nack", scl_drive, 1'b0);
    bus_stop();
    pulse_xmit_clr();
    pulse_xempty_clr();
    ack_val = 1'b0;
  endtask

  task automatic t_disable();
    logic ack;
    mod_en = 1'b0; wclk(2);
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    chk("R1 disabled no ack", ack, 1'b1);
    chk("R1 disabled no flag", {xmit, xempty, xend}, 3'b000);
    chk("R1 disabled lines released", {scl_drive, sda_drive}, 2'b00);
    bus_stop();
    mod_en = 1'b1; wclk(2);
  endtask

  task automatic t_stop_restart();
    logic ack, s;
    logic [7:0] d;
    bus_start();
    clock_bit(1'b1, s);
    clock_bit(1'b0, s);
    clock_bit(1'b1, s);
    clock_bit(1'b1, s);
    bus_stop();
    chk("R10 released after stop mid frame", {scl_drive, sda_drive}, 2'b00);
    chk("R10 no flags after aborted frame", xmit, 1'b0);
    bus_start();
    send_byte({ADDR, 1'b1}, ack);
    chk("R10 fresh address acknowledged", ack, 1'b0);
    pulse_wr(8'h96); wclk(3);
    read_byte(1'b1, d);
    chk("R10 byte after restart", d, 8'h96);
    end_proc("restart");
  endtask

  initial begin
    rst_n = 1'b0; mod_en = 1'b1; slv_addr = ADDR; ack_val = 1'b0;
    txd_wr = 1'b0; txd = '0; xmit_clr = 1'b0; xend_clr = 1'b0;
    xempty_clr = 1'b0; rxd_rd = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_read_basic();
    t_stretch();
    t_nack();
    t_mismatch();
    t_write_addr();
    t_ack_level();
    t_disable();
    t_stop_restart();
    wclk(10);
    summary();
    $finish;
  end

endmodule